// File: doc/BRIEF.md
# Vector Compare-Immediate Sequencer with Data-Dependent Early Exit

The block walks a compare-immediate across a vector of up to `MAXVL` elements. It holds a small integer register file and an array of 4-bit condition fields. For each element it compares one integer register, treated as signed, with a signed immediate. It then writes the result flags into one condition field. The source register and the destination field are each either a vector operand or a scalar operand. A vector operand steps to the next entry after every element. A scalar operand stays fixed. With these two flags, scalar-scalar, scalar-vector, vector-scalar and vector-vector forms all run on the same datapath.

An optional early-exit mode applies a programmable test to each freshly written field. The test picks one flag bit and the polarity that counts as failure. The first element that fails ends the loop, and the block reports a shortened vector length. Inclusive truncation keeps the failing element in the count. Exclusive truncation drops it, so a failure on element zero reports a length of zero. Software loads the integer registers through a write port and reads condition fields back through a registered read port.

Top module: `vcmp_ff_top`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0 and `vl_out` is 0.
- R2: Each written field is signed-compare(reg, imm) encoded as bit 3 = less-than, bit 2 = greater-than, bit 1 = equal, bit 0 = summary-overflow, which is always written 0; exactly one of bits 3..1 is set.
- R3: Element i reads register `(ra + i) mod NGPR` when `ra_vec` = 1, and register `ra` for every element when `ra_vec` = 0.
- R4: Element i writes field `(ba + i) mod NCF` when `ba_vec` = 1, and field `ba` for every element when `ba_vec` = 0, so that field ends with the result of the last element processed.
- R5: One element is processed per clock. If `start` is sampled at edge E0 and n elements are written, `done` is high for exactly the cycle after edge En, and `busy` is high after edges E0..E(n-1).
- R6: With `ff_en` = 0, all `vl_in` elements are written and `vl_out` equals `vl_in`.
- R7: An element fails when bit `test_sel` of its new field equals `test_pol`. With `ff_en` = 1, the first failing element ends the loop, and no later element is written.
- R8: With inclusive truncation (`ff_incl` = 1), a failure at element i reports `vl_out` = i+1.
- R9: With exclusive truncation (`ff_incl` = 0), a failure at element i reports `vl_out` = i, including 0 for i = 0. The failing element's field is still written.
- R10: A start with `vl_in` = 0 writes no field and raises `done` right after the start edge, with `vl_out` = 0.
- R11: A `start` sampled while `busy` is high is ignored: the running loop's timing, writes and result are unchanged.
- R12: `vl_out` changes only at the edge that raises `done`, and `done` is a single-cycle pulse.
- R13: `cf_rdata` presents field `cf_raddr` one clock after the address is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe, sampled while idle |
| ra | input | GAW | First source register number |
| ba | input | CAW | First destination field number |
| imm | input | XLEN | Signed immediate |
| vl_in | input | VLW | Requested vector length |
| ra_vec | input | 1 | Source steps per element |
| ba_vec | input | 1 | Destination steps per element |
| ff_en | input | 1 | Enable early exit on test failure |
| ff_incl | input | 1 | 1: inclusive truncation, 0: exclusive |
| test_sel | input | 2 | Flag bit tested (3 LT, 2 GT, 1 EQ, 0 SO) |
| test_pol | input | 1 | Flag value that counts as failure |
| gpr_we | input | 1 | Integer register write enable |
| gpr_waddr | input | GAW | Integer register write address |
| gpr_wdata | input | XLEN | Integer register write data |
| cf_raddr | input | CAW | Condition field read address |
| cf_rdata | output | 4 | Registered condition field read data |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle completion pulse |
| vl_out | output | VLW | Resulting vector length |

## Verification
With `start` sampled at edge E0, the result of element k lands in its field at edge E(k+1). `done`, `busy` and `vl_out` settle at edge En, where n is the number of elements written. A readback appears one edge after its address is applied. The bench's behavioural model works out n, the truncated length and every field write before launch. It then compares `done` and `busy` on the falling edge after each of E0..En, and takes `vl_out` in the `done` cycle and again three cycles later. Fields are read back one address per clock, each compared on the falling edge after the registering edge.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  localparam int CF_W  = 4;
  localparam int CF_LT = 3;
  localparam int CF_GT = 2;
  localparam int CF_EQ = 1;
  localparam int CF_SO = 0;
  typedef logic [CF_W-1:0] cfield_t;
endpackage

// File: rtl/vcmp_gpr.sv
// Integer register file: one synchronous write port, one asynchronous read port.
module vcmp_gpr #(
  parameter int XLEN  = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [XLEN-1:0] rdata
);
  logic [XLEN-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/vcmp_crf.sv
// Condition field array: one write port, one registered read port (block RAM shape).
module vcmp_crf #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  vcmp_pkg::cfield_t      wdata,
  input  logic [AW-1:0]          raddr,
  output vcmp_pkg::cfield_t      rdata
);
  vcmp_pkg::cfield_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vcmp_cmp.sv
// Signed compare against the immediate, plus the early-exit test on the result.
module vcmp_cmp #(
  parameter int XLEN = 16
) (
  input  logic [XLEN-1:0]   opnd,
  input  logic [XLEN-1:0]   imm,
  input  logic [1:0]        test_sel,
  input  logic              test_pol,
  output vcmp_pkg::cfield_t cf,
  output logic              fail
);
  always_comb begin
    cf = '0;
    if ($signed(opnd) < $signed(imm))      cf[vcmp_pkg::CF_LT] = 1'b1;
    else if ($signed(opnd) > $signed(imm)) cf[vcmp_pkg::CF_GT] = 1'b1;
    else                                   cf[vcmp_pkg::CF_EQ] = 1'b1;
    fail = (cf[test_sel] == test_pol);
  end
endmodule

// File: rtl/vcmp_ff_top.sv
module vcmp_ff_top #(
  parameter int XLEN  = 16,
  parameter int NGPR  = 16,
  parameter int NCF   = 16,
  parameter int MAXVL = 16,
  localparam int GAW  = $clog2(NGPR),
  localparam int CAW  = $clog2(NCF),
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [GAW-1:0]       ra,
  input  logic [CAW-1:0]       ba,
  input  logic [XLEN-1:0]      imm,
  input  logic [VLW-1:0]       vl_in,
  input  logic                 ra_vec,
  input  logic                 ba_vec,
  input  logic                 ff_en,
  input  logic                 ff_incl,
  input  logic [1:0]           test_sel,
  input  logic                 test_pol,
  input  logic                 gpr_we,
  input  logic [GAW-1:0]       gpr_waddr,
  input  logic [XLEN-1:0]      gpr_wdata,
  input  logic [CAW-1:0]       cf_raddr,
  output logic [3:0]           cf_rdata,
  output logic                 busy,
  output logic                 done,
  output logic [VLW-1:0]       vl_out
);
  logic              busy_q, done_q;
  logic [VLW-1:0]    idx_q, vl_q, vl_out_q;
  logic [GAW-1:0]    src_q;
  logic [CAW-1:0]    dst_q;
  logic [XLEN-1:0]   imm_q;
  logic              rvec_q, bvec_q, ff_q, incl_q, tpol_q;
  logic [1:0]        tsel_q;

  logic [XLEN-1:0]   opnd;
  vcmp_pkg::cfield_t cf_new, cf_rd;
  logic              elem_fail, last_elem, stop_now;

  vcmp_gpr #(.XLEN(XLEN), .DEPTH(NGPR)) u_gpr (
    .clk(clk), .we(gpr_we), .waddr(gpr_waddr), .wdata(gpr_wdata),
    .raddr(src_q), .rdata(opnd)
  );

  vcmp_cmp #(.XLEN(XLEN)) u_cmp (
    .opnd(opnd), .imm(imm_q), .test_sel(tsel_q), .test_pol(tpol_q),
    .cf(cf_new), .fail(elem_fail)
  );

  vcmp_crf #(.DEPTH(NCF)) u_crf (
    .clk(clk), .we(busy_q), .waddr(dst_q), .wdata(cf_new),
    .raddr(cf_raddr), .rdata(cf_rd)
  );

  assign last_elem = (idx_q == vl_q - 1'b1);
  assign stop_now  = ff_q && elem_fail;

  // Control and result registers
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      vl_out_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          if (vl_in == '0) begin
            done_q   <= 1'b1;
            vl_out_q <= '0;
          end else begin
            busy_q <= 1'b1;
          end
        end
      end else if (stop_now || last_elem) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        vl_out_q <= stop_now ? (incl_q ? idx_q + 1'b1 : idx_q) : vl_q;
      end
    end
  end

  // Loop state and captured operation (no reset needed)
  always_ff @(posedge clk) begin
    if (!busy_q) begin
      if (start) begin
        idx_q  <= '0;
        src_q  <= ra;
        dst_q  <= ba;
        vl_q   <= vl_in;
        imm_q  <= imm;
        rvec_q <= ra_vec;
        bvec_q <= ba_vec;
        ff_q   <= ff_en;
        incl_q <= ff_incl;
        tsel_q <= test_sel;
        tpol_q <= test_pol;
      end
    end else begin
      idx_q <= idx_q + 1'b1;
      if (rvec_q) src_q <= src_q + 1'b1;
      if (bvec_q) dst_q <= dst_q + 1'b1;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign vl_out   = vl_out_q;
  assign cf_rdata = cf_rd;
endmodule

// File: rtl/vcmp_ff_chk.sv
module vcmp_ff_chk #(
  parameter int VLW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [VLW-1:0] vl_out,
  input logic [VLW-1:0] vl_cap
);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_busy_end_done_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_busy_from_start_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  p_vl_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> $stable(vl_out));

  p_vl_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (done && $past(busy)) |-> (vl_out <= vl_cap));
endmodule

bind vcmp_ff_top vcmp_ff_chk #(.VLW(VLW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .vl_out(vl_out), .vl_cap(vl_q)
);

// File: tb/sim_vcmp_ff_top.sv
`timescale 1ns/1ps
module sim_vcmp_ff_top;
  localparam int NG = 16;
  localparam int NC = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [3:0] ra = '0, ba = '0, gpr_waddr = '0, cf_raddr = '0;
  logic [15:0] imm = '0, gpr_wdata = '0;
  logic [4:0] vl_in = '0;
  logic ra_vec = 1'b0, ba_vec = 1'b0, ff_en = 1'b0, ff_incl = 1'b0, test_pol = 1'b0;
  logic [1:0] test_sel = '0;
  logic gpr_we = 1'b0;
  logic [3:0] cf_rdata;
  logic busy, done;
  logic [4:0] vl_out;

  int checks = 0;
  int failures = 0;
  int gpr_m [NG];
  int cf_m  [NC];

  always #2.5 clk = ~clk;

  vcmp_ff_top u0 (
    .clk(clk), .rst(rst), .start(start), .ra(ra), .ba(ba), .imm(imm),
    .vl_in(vl_in), .ra_vec(ra_vec), .ba_vec(ba_vec), .ff_en(ff_en),
    .ff_incl(ff_incl), .test_sel(test_sel), .test_pol(test_pol),
    .gpr_we(gpr_we), .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata),
    .cf_raddr(cf_raddr), .cf_rdata(cf_rdata), .busy(busy), .done(done),
    .vl_out(vl_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_gpr(input int idx, input int val);
    gpr_we = 1'b1; gpr_waddr = idx[3:0]; gpr_wdata = val[15:0];
    step();
    gpr_we = 1'b0;
    gpr_m[idx] = val;
  endtask

  task automatic readback(input string req);
    for (int c = 0; c < NC; c++) begin
      cf_raddr = c[3:0];
      step();
      if (cf_m[c] >= 0) chk(cf_rdata == cf_m[c][3:0], req, int'(cf_rdata), cf_m[c]);
    end
  endtask

  // Behavioural model predicts all writes, n and the length; then compares each clock.
  task automatic run_op(input string req, input int a, input int b, input int im,
                        input int vl, input bit rv, input bit bv, input bit ff,
                        input bit incl, input int tsel, input bit tpol, input bit poke);
    int n, vexp, v, cf, src, dst;
    bit stop;
    n = 0; vexp = vl; stop = 1'b0;
    for (int i = 0; i < vl && !stop; i++) begin
      src = (a + (rv ? i : 0)) % NG;
      dst = (b + (bv ? i : 0)) % NC;
      v = gpr_m[src];
      cf = (v < im) ? 8 : ((v > im) ? 4 : 2);
      cf_m[dst] = cf;
      n = i + 1;
      if (ff && (((cf >> tsel) & 1) == int'(tpol))) begin
        vexp = incl ? i + 1 : i;
        stop = 1'b1;
      end
    end
    ra = a[3:0]; ba = b[3:0]; imm = im[15:0]; vl_in = vl[4:0];
    ra_vec = rv; ba_vec = bv; ff_en = ff; ff_incl = incl;
    test_sel = tsel[1:0]; test_pol = tpol; start = 1'b1;
    step();
    start = 1'b0;
    for (int k = 0; k <= n; k++) begin
      if (k > 0) begin
        if (poke && k == 2) begin
          start = 1'b1; ra = 4'd9; ba = 4'd1; vl_in = 5'd2; ff_en = 1'b1;
        end
        step();
        start = 1'b0;
      end
      chk(done == (k == n), {req, " done timing (R5)"}, int'(done), int'(k == n));
      chk(busy == (k < n), {req, " busy timing (R5)"}, int'(busy), int'(k < n));
      if (k == n) chk(vl_out == vexp[4:0], {req, " vl_out"}, int'(vl_out), vexp);
    end
    repeat (3) step();
    chk(vl_out == vexp[4:0] && !done, "R12 vl_out held, done single pulse", int'(vl_out), vexp);
    readback({req, " fields (R2 R13)"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R5 watchdog expired actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) cf_m[c] = -1;
    repeat (3) step();
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    chk(vl_out == 5'd0, "R1 reset vl_out", int'(vl_out), 0);
    rst = 1'b0;
    step();
    // Register k holds 10k-50: -50 .. 100
    for (int k = 0; k < NG; k++) load_gpr(k, 10 * k - 50);

    // R6 R3 R4: vector-vector over all fields, no early exit
    run_op("R6 full vv", 0, 0, 0, 16, 1, 1, 0, 0, 0, 0, 0);
    // R3: scalar source (reg 7 = 20) into vector destination, all equal
    run_op("R3 scalar src", 7, 3, 20, 4, 0, 1, 0, 0, 0, 0, 0);
    // R4: vector source into scalar destination; field 9 keeps last result
    run_op("R4 scalar dst", 2, 9, 0, 5, 1, 0, 0, 0, 0, 0, 0);
    // R3 R4: both indices wrap around the top
    run_op("R4 wrap", 14, 14, 25, 4, 1, 1, 0, 0, 0, 0, 0);
    // R7 R8: fail when LT is clear, first at element 5 (reg 5 = 0)
    run_op("R8 inclusive", 0, 0, 0, 10, 1, 1, 1, 1, 3, 0, 0);
    // R9: same test, exclusive, different destination
    run_op("R9 exclusive", 0, 6, 0, 10, 1, 1, 1, 0, 3, 0, 0);
    // R9: failure on element 0 gives length zero; field still written
    run_op("R9 exclusive zero", 0, 11, 0, 6, 1, 1, 1, 0, 3, 1, 0);
    // R7: early exit on EQ set, reg 8 = 30 at element 6
    run_op("R7 eq exit", 2, 0, 30, 12, 1, 1, 1, 1, 1, 1, 0);
    // R6 R7: early exit enabled but no element fails
    run_op("R7 no failure", 0, 4, 200, 7, 1, 1, 1, 0, 2, 1, 0);
    // R10: zero length writes nothing
    run_op("R10 zero vl", 3, 5, 99, 0, 1, 1, 0, 0, 0, 0, 0);
    // R11: start pulsed while busy is ignored
    run_op("R11 start while busy", 1, 2, -10, 6, 1, 1, 0, 0, 0, 0, 1);
    // R2: SO bit never set, inclusive exit on SO clear at element 0
    run_op("R2 so test", 15, 13, -100, 5, 0, 1, 1, 1, 0, 0, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule